// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Timeout

This block is a countdown watchdog for a system controller. Software programs an 8-bit control word holding an enable, an interrupt-first mode bit, a one-way freeze bit and a 4-bit period selector. It must then strobe the restart input often enough that the counter never runs out. When the counter expires, the block either pulses a request to the chip's reset generator, or, in interrupt-first mode, first raises an interrupt and starts another full period. If that interrupt is still outstanding when the second period expires, the reset request follows.

The period is a power of two. Its exponent is a parameter base plus the selector. A changed selector stays latent until the counter is next reloaded, by a restart strobe or by an expiry. A small state machine tracks the interrupt. It has two states: `WD_CALM` (no interrupt outstanding) and `WD_ALERT` (interrupt outstanding). Its transitions are: *warn* (`WD_CALM` to `WD_ALERT` on an expiry with interrupt-first set), *acknowledge* (`WD_ALERT` to `WD_CALM` on the clear strobe), *escalate* (`WD_ALERT` stays in `WD_ALERT` and pulses the reset request on an expiry with no clear) and *bite* (`WD_CALM` stays in `WD_CALM` and pulses the reset request on an expiry with interrupt-first clear). A clear strobe that lands in the same cycle as an expiry is applied first, so that expiry counts as a first timeout.

Top module: `wdog_timer`

## Requirements
- R1: After system reset the control word reads 0, and both `irq` and `rst_req` are low.
- R2: The control word reads back EN at bit 0, IF at bit 1, FRZ at bit 3 and TOP at bits 7:4. Bit 2 and bits 31:8 read as 0 whatever is written.
- R3: A counter load sets a period of 2^(EXP_BASE+TOP) clock cycles. With the default EXP_BASE of 16 this spans 2^16 to 2^31 cycles. An expiry reloads the counter using the current TOP.
- R4: Writing TOP does not change the count already running. The new period applies only from the next restart or expiry.
- R5: A `kick` strobe reloads the counter from the current TOP, and kicks spaced closer than one period prevent any timeout.
- R6: While EN is 0 the counter holds its value, and neither `irq` nor `rst_req` is raised. On re-enable the count resumes from where it stopped.
- R7: With IF at 0, every expiry produces a `rst_req` pulse exactly one cycle wide.
- R8: With IF at 1, an expiry with no interrupt outstanding raises `irq` without any `rst_req`. `irq` stays high until an `irq_clr` strobe.
- R9: An expiry while `irq` is outstanding (and not cleared that cycle) produces a `rst_req` pulse, and `irq` stays high.
- R10: FRZ is set by writing 1 to bit 3, and writing 0 never clears it.
- R11: While FRZ and EN are both 1, a write with bit 0 at 0 leaves EN at 1.
- R12: System reset drops an outstanding `irq` and returns all control bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous assert |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | DATA_W | Control word write value |
| rd_data | output | DATA_W | Current control word |
| kick | input | 1 | Restart strobe, reloads the counter |
| irq_clr | input | 1 | Clears an outstanding interrupt |
| irq | output | 1 | Interrupt level from the first timeout |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with EXP_BASE set to 4, so TOP values 0 to 2 give periods of 16, 32 and 64 cycles. At that scale, exact expiry cycles, the deferred switch between two periods, interrupt-then-reset escalation and a long run of regular kicks can all be observed cycle by cycle. The default of 16 is only elaborated, because periods of up to 2^31 cycles cannot be waited out.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int TOP_W   = 4;
    localparam int CTL_W   = 8;
    localparam int BIT_EN  = 0;
    localparam int BIT_IF  = 1;
    localparam int BIT_FRZ = 3;
    localparam int TOP_LSB = 4;

    typedef struct packed {
        logic [TOP_W-1:0] top;
        logic             frz;
        logic             ifm;
        logic             en;
    } wdog_ctl_t;

    typedef enum logic {
        WD_CALM  = 1'b0,
        WD_ALERT = 1'b1
    } wdog_state_e;

endpackage

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_byte,
    output wdog_ctl_t        ctl,
    output logic [CTL_W-1:0] rd_byte
);

    logic en_locked;
    assign en_locked = ctl.frz && ctl.en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_en) begin
            ctl.top <= wr_byte[TOP_LSB +: TOP_W];
            ctl.ifm <= wr_byte[BIT_IF];
            ctl.frz <= ctl.frz | wr_byte[BIT_FRZ];
            ctl.en  <= en_locked ? 1'b1 : wr_byte[BIT_EN];
        end
    end

    always_comb begin
        rd_byte                        = '0;
        rd_byte[BIT_EN]                = ctl.en;
        rd_byte[BIT_IF]                = ctl.ifm;
        rd_byte[BIT_FRZ]               = ctl.frz;
        rd_byte[TOP_LSB +: TOP_W]      = ctl.top;
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int EXP_BASE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             kick,
    input  logic [TOP_W-1:0] top,
    output logic             expire
);

    localparam int CNT_W = EXP_BASE + (1 << TOP_W);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;

    assign reload = CNT_W'(1) << (EXP_BASE + int'(top));
    assign expire = en && !kick && (cnt == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= CNT_W'(1) << EXP_BASE;
        end else if (kick || expire) begin
            cnt <= reload;
        end else if (en) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ifm,
    input  logic irq_clr,
    output logic irq,
    output logic rst_req
);

    wdog_state_e state, state_nx;
    logic        pending;
    logic        bite;

    assign pending = (state == WD_ALERT) && !irq_clr;
    assign bite    = expire && (pending || !ifm);

    always_comb begin
        state_nx = state;
        unique case (state)
            WD_CALM:  if (expire && ifm) state_nx = WD_ALERT;
            WD_ALERT: if (irq_clr) state_nx = (expire && ifm) ? WD_ALERT : WD_CALM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_CALM;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            irq     <= (state_nx == WD_ALERT);
            rst_req <= bite;
        end
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int EXP_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              kick,
    input  logic              irq_clr,
    output logic              irq,
    output logic              rst_req
);

    wdog_ctl_t        ctl;
    logic [CTL_W-1:0] rd_byte;
    logic             expire;
    logic             unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DATA_W-1:CTL_W];
    assign rd_data      = {{(DATA_W-CTL_W){1'b0}}, rd_byte};

    wdog_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_byte (wr_data[CTL_W-1:0]),
        .ctl     (ctl),
        .rd_byte (rd_byte)
    );

    wdog_counter #(.EXP_BASE(EXP_BASE)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctl.en),
        .kick   (kick),
        .top    (ctl.top),
        .expire (expire)
    );

    wdog_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .ifm     (ctl.ifm),
        .irq_clr (irq_clr),
        .irq     (irq),
        .rst_req (rst_req)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctl_rd,
    input logic       irq,
    input logic       irq_clr,
    input logic       rst_req
);

    assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_reset_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(ctl_rd[0]));

    assert_irq_rise_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ctl_rd[0]) && $past(ctl_rd[1])));

    assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_clr));

    assert_frz_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_rd[3]) |-> ctl_rd[3]);

    assert_en_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_rd[3]) && $past(ctl_rd[0])) |-> ctl_rd[0]);

endmodule

bind wdog_timer wdog_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_rd  (rd_data[7:0]),
    .irq     (irq),
    .irq_clr (irq_clr),
    .rst_req (rst_req)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;

    localparam int EXPB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        kick = 1'b0;
    logic        irq_clr = 1'b0;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    int rst_pulses = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdog_timer #(.DATA_W(32), .EXP_BASE(EXPB)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .kick(kick), .irq_clr(irq_clr),
        .irq(irq), .rst_req(rst_req)
    );

    always @(negedge clk) if (rst_req) rst_pulses++;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_ctl(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic wait_for(input bit on_irq, input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (on_irq ? irq : rst_req) break;
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 ctl", rd_data, 0);
        check("R1 irq", irq, 0);
        check("R1 rst_req", rst_req, 0);
    endtask

    task automatic t_layout();
        do_reset();
        write_ctl(32'hFFFF_FFF4);
        check("R2 reserved/TOP", rd_data, 32'h0000_00F0);
        write_ctl(32'h0000_0003);
        check("R2 EN/IF", rd_data, 32'h3);
    endtask

    task automatic t_bite_and_defer();
        int n;
        int p0;
        do_reset();
        write_ctl(32'h11);
        wait_for(0, 200, n);
        check("R4 old period kept", n, 16);
        check("R7 irq stays low", irq, 0);
        p0 = rst_pulses;
        @(negedge clk);
        check("R7 one-cycle pulse", rst_req, 0);
        check("R7 pulse count", rst_pulses - p0, 1);
        wait_for(0, 200, n);
        check("R3 reload with TOP=1", n, 31);
        write_ctl(32'h21);
        pulse_kick();
        wait_for(0, 200, n);
        check("R5 kick loads TOP=2", n, 64);
    endtask

    task automatic t_kicking();
        int p0;
        do_reset();
        write_ctl(32'h1);
        p0 = rst_pulses;
        for (int k = 0; k < 12; k++) begin
            repeat (10) @(negedge clk);
            pulse_kick();
        end
        check("R5 kicks hold off reset", rst_pulses - p0, 0);
    endtask

    task automatic t_disable();
        int n;
        int p0;
        do_reset();
        write_ctl(32'h1);
        repeat (5) @(negedge clk);
        write_ctl(32'h0);
        p0 = rst_pulses;
        repeat (40) @(negedge clk);
        check("R6 no reset while off", rst_pulses - p0, 0);
        check("R6 no irq while off", irq, 0);
        write_ctl(32'h1);
        wait_for(0, 200, n);
        check("R6 count resumes", n, 10);
    endtask

    task automatic t_irq_escalate();
        int n;
        int p0;
        do_reset();
        p0 = rst_pulses;
        write_ctl(32'h3);
        wait_for(1, 200, n);
        check("R8 irq at first timeout", n, 16);
        check("R8 no reset on first", rst_pulses - p0, 0);
        wait_for(0, 200, n);
        check("R9 reset on second", n, 16);
        check("R9 irq still high", irq, 1);
        @(negedge clk);
        check("R9 pulse width", rst_req, 0);
        do_reset();
        check("R12 irq cleared", irq, 0);
        check("R12 ctl cleared", rd_data, 0);
    endtask

    task automatic t_irq_clear();
        int n;
        int p0;
        do_reset();
        p0 = rst_pulses;
        write_ctl(32'h3);
        wait_for(1, 200, n);
        pulse_clr();
        check("R8 clear drops irq", irq, 0);
        wait_for(1, 200, n);
        check("R8 re-warn after clear", n, 15);
        check("R8 no reset after clear", rst_pulses - p0, 0);
    endtask

    task automatic t_freeze();
        do_reset();
        write_ctl(32'h9);
        check("R10 frz set", rd_data, 32'h9);
        write_ctl(32'h0);
        check("R11 en locked, R10 frz kept", rd_data, 32'h9);
        write_ctl(32'h2);
        check("R11 write keeps en", rd_data, 32'hB);
        do_reset();
        check("R12 frz cleared", rd_data, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_layout();
        t_bite_and_defer();
        t_kicking();
        t_disable();
        t_irq_escalate();
        t_irq_clear();
        t_freeze();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule